// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block walks a circular ring of two-word transmit descriptors kept in host memory. Software fills descriptors, sets their ownership bit to hand them to hardware, and issues a one-cycle kick. The walker then reads the descriptor at its current ring position. For every descriptor that hardware owns, it hands the buffer address, the byte length and the start/end-of-packet flags to a downstream data mover. When the mover accepts the request, the walker writes the flags word back with the ownership bit cleared and steps to the next slot. It stops at the first descriptor that software still owns and then waits for the next kick.

The ring position is a 21-bit base, aligned to 2 KB, joined to an 8-bit slot index. The ring length is chosen in steps of 16 entries. Each descriptor the walker returns produces a one-cycle pulse. A separate end-of-work pulse marks the end of a walk. Depending on a mode input, it fires either as soon as the walk stops or once the downstream FIFO reports that it is empty. A further pulse reports a packet whose descriptors ended without an end-of-packet mark.

Top module: `txring_walker`

## Requirements
- R1: After synchronous reset, every output is low, and the slot index is 0.
- R2: For an owned descriptor with a nonzero length, the transfer request carries the following fields until `xfer_ready` accepts it:
  - the address from word 1;
  - the length from word 0 bits 13:0;
  - SOP from bit 30;
  - EOP from bit 29.
- R3: After the transfer is accepted, word 0 is written back with bit 31 (ownership, 1 = hardware) cleared and bits 30:0 unchanged. `desc_done` then pulses for exactly one cycle for that descriptor.
- R4: A descriptor with length 0 produces no transfer request, but it is still written back and still pulses `desc_done`.
- R5: The flags word of slot i is at byte address {ring_base, i, 3'b000}, and the buffer address word is at that address plus 4.
- R6: Size code n gives 16·(n+1) slots. The index wraps from 16·(n+1)−1 to 0.
- R7: On reaching a descriptor with bit 31 = 0, the walker issues no transfer and no write for it, and the index stays on that slot. The next kick resumes from that slot.
- R8: A kick stays pending while `dma_en` is low, and no memory access occurs in that time. The walk starts once `dma_en` is set.
- R9: With `drain_mode` = 0, `all_done` pulses once when a walk stops after returning at least one descriptor. A walk that returns none gives no pulse.
- R10: With `drain_mode` = 1, the pulse waits until `fifo_empty` is high after the walk has stopped.
- R11: `eop_err` pulses when a descriptor with SOP is handed off while the previous packet never carried EOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_en | input | 1 | Allows descriptor fetches |
| drain_mode | input | 1 | 0: end pulse at stop; 1: end pulse after FIFO empty |
| ring_base | input | 21 | Aligned ring base (address bits 31:11) |
| size_code | input | 4 | Ring length code, 16·(n+1) slots |
| kick | input | 1 | One-cycle transmit-pending command |
| ring_idx | output | 8 | Current slot index |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write-back, 0 for read |
| mem_addr | output | 32 | Byte address of the accessed word |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_ready | input | 1 | Data mover accepts the request |
| xfer_addr | output | 32 | Buffer address |
| xfer_len | output | 14 | Buffer length in bytes |
| xfer_sop | output | 1 | Buffer begins a packet |
| xfer_eop | output | 1 | Buffer ends a packet |
| fifo_empty | input | 1 | Downstream FIFO empty |
| desc_done | output | 1 | Pulse per returned descriptor |
| all_done | output | 1 | End-of-work pulse |
| eop_err | output | 1 | Missing end-of-packet pulse |

## Verification
The walker is run at three ring sizes: the smallest, the next one up and the largest. Each run uses two batches, and the second batch crosses the wrap point, so an off-by-one in the slot limit shows up as a wrong final index or as a descriptor that is never returned.

The batches mix several kinds of length:
- ordinary lengths;
- the maximum length;
- zero lengths, which separate skipped transfers from skipped write-backs.

Dedicated runs cover the remaining behaviour:
- a kick with fetching disabled;
- a kick with nothing owned;
- a walk in drain mode with the FIFO held non-empty;
- an SOP/EOP sequence with exactly one unterminated packet.

// File: rtl/txw_pkg.sv
package txw_pkg;

    localparam int DW    = 32;
    localparam int LEN_W = 14;

    // Word 0 of a descriptor, most significant field first.
    typedef struct packed {
        logic              own;     // 1: hardware owns the slot
        logic              sop;
        logic              eop;
        logic              cs_en;
        logic [7:0]        cs_stuff;
        logic [5:0]        cs_start;
        logic [LEN_W-1:0]  len;
    } txd_flags_t;

    typedef enum logic [2:0] {
        W_IDLE,
        W_FETCH_FLAGS,
        W_FETCH_ADDR,
        W_HANDOFF,
        W_RETURN,
        W_DRAIN
    } walk_state_t;

    function automatic txd_flags_t release_flags(input txd_flags_t f);
        txd_flags_t r;
        r     = f;
        r.own = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr #(
    parameter int SZ_W    = 4,
    parameter int STEP_LG = 4,
    localparam int DISP_W = SZ_W + STEP_LG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    input  logic [SZ_W-1:0]   size_code,
    output logic [DISP_W-1:0] disp
);

    logic [DISP_W-1:0] last_slot;

    // 16*(n+1)-1 equals the code followed by all-ones step bits
    assign last_slot = {size_code, {STEP_LG{1'b1}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            disp <= '0;
        end else if (advance) begin
            if (disp >= last_slot)
                disp <= '0;
            else
                disp <= disp + 1'b1;
        end
    end

endmodule

// File: rtl/txw_pkt_track.sv
module txw_pkt_track (
    input  logic clk,
    input  logic rst,
    input  logic handoff,
    input  logic sop,
    input  logic eop,
    output logic eop_err
);

    logic in_pkt;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt  <= 1'b0;
            eop_err <= 1'b0;
        end else begin
            eop_err <= handoff && sop && in_pkt;
            if (handoff) begin
                if (eop)
                    in_pkt <= 1'b0;
                else if (sop)
                    in_pkt <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/txw_seq.sv
module txw_seq
    import txw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              drain_mode,
    input  logic              kick,
    input  logic              fifo_empty,
    input  logic [ADDR_W-1:0] desc_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [DW-1:0]     xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_sop,
    output logic              xfer_eop,
    output logic              handoff,
    output txd_flags_t        cur_flags,
    output logic              all_done
);

    walk_state_t state;
    logic        pending;
    logic        served;
    txd_flags_t  flags_q;
    txd_flags_t  rd_flags;
    logic [DW-1:0] baddr_q;
    logic        accept;
    logic        stop_now;

    assign rd_flags = txd_flags_t'(mem_rdata);
    assign accept   = (state == W_IDLE) && pending && dma_en;
    assign stop_now = (state == W_FETCH_FLAGS) &&
                      (!dma_en || (mem_ack && !rd_flags.own));

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= W_IDLE;
            pending  <= 1'b0;
            served   <= 1'b0;
            flags_q  <= '0;
            baddr_q  <= '0;
            all_done <= 1'b0;
        end else begin
            all_done <= 1'b0;
            pending  <= kick | (pending & ~accept);
            case (state)
                W_IDLE: begin
                    if (accept) begin
                        served <= 1'b0;
                        state  <= W_FETCH_FLAGS;
                    end
                end
                W_FETCH_FLAGS: begin
                    if (stop_now) begin
                        if (!served) begin
                            state <= W_IDLE;
                        end else if (drain_mode) begin
                            state <= W_DRAIN;
                        end else begin
                            all_done <= 1'b1;
                            state    <= W_IDLE;
                        end
                    end else if (mem_ack) begin
                        flags_q <= rd_flags;
                        state   <= W_FETCH_ADDR;
                    end
                end
                W_FETCH_ADDR: begin
                    if (mem_ack) begin
                        baddr_q <= mem_rdata;
                        state   <= (flags_q.len == '0) ? W_RETURN : W_HANDOFF;
                    end
                end
                W_HANDOFF: begin
                    if (xfer_ready)
                        state <= W_RETURN;
                end
                W_RETURN: begin
                    if (mem_ack) begin
                        served <= 1'b1;
                        state  <= W_FETCH_FLAGS;
                    end
                end
                W_DRAIN: begin
                    if (fifo_empty) begin
                        all_done <= 1'b1;
                        state    <= W_IDLE;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = ((state == W_FETCH_FLAGS) && dma_en) ||
                    (state == W_FETCH_ADDR) || (state == W_RETURN);
        mem_we    = (state == W_RETURN);
        mem_addr  = {desc_addr[ADDR_W-1:3], (state == W_FETCH_ADDR), 2'b00};
        mem_wdata = DW'(release_flags(flags_q));
    end

    assign xfer_valid = (state == W_HANDOFF);
    assign xfer_addr  = baddr_q;
    assign xfer_len   = flags_q.len;
    assign xfer_sop   = flags_q.sop;
    assign xfer_eop   = flags_q.eop;
    assign handoff    = (state == W_RETURN) && mem_ack;
    assign cur_flags  = flags_q;

endmodule

// File: rtl/txring_walker.sv
module txring_walker
    import txw_pkg::*;
#(
    parameter int BASE_W  = 21,
    parameter int SZ_W    = 4,
    parameter int STEP_LG = 4,
    localparam int DISP_W = SZ_W + STEP_LG,
    localparam int ADDR_W = BASE_W + DISP_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dma_en,
    input  logic              drain_mode,
    input  logic [BASE_W-1:0] ring_base,
    input  logic [SZ_W-1:0]   size_code,
    input  logic              kick,
    output logic [DISP_W-1:0] ring_idx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              xfer_valid,
    input  logic              xfer_ready,
    output logic [DW-1:0]     xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_sop,
    output logic              xfer_eop,
    input  logic              fifo_empty,
    output logic              desc_done,
    output logic              all_done,
    output logic              eop_err
);

    logic              handoff;
    txd_flags_t        cur_flags;
    logic [ADDR_W-1:0] desc_addr;

    assign desc_addr = {ring_base, ring_idx, 3'b000};

    txw_ring_ptr #(.SZ_W(SZ_W), .STEP_LG(STEP_LG)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .advance   (handoff),
        .size_code (size_code),
        .disp      (ring_idx)
    );

    txw_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .dma_en     (dma_en),
        .drain_mode (drain_mode),
        .kick       (kick),
        .fifo_empty (fifo_empty),
        .desc_addr  (desc_addr),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .xfer_valid (xfer_valid),
        .xfer_ready (xfer_ready),
        .xfer_addr  (xfer_addr),
        .xfer_len   (xfer_len),
        .xfer_sop   (xfer_sop),
        .xfer_eop   (xfer_eop),
        .handoff    (handoff),
        .cur_flags  (cur_flags),
        .all_done   (all_done)
    );

    txw_pkt_track u_track (
        .clk     (clk),
        .rst     (rst),
        .handoff (handoff),
        .sop     (cur_flags.sop),
        .eop     (cur_flags.eop),
        .eop_err (eop_err)
    );

    always_ff @(posedge clk) begin
        if (rst)
            desc_done <= 1'b0;
        else
            desc_done <= handoff;
    end

endmodule

// File: rtl/txw_checker.sv
module txw_checker
    import txw_pkg::*;
#(
    parameter int BASE_W  = 21,
    parameter int SZ_W    = 4,
    parameter int STEP_LG = 4,
    localparam int DISP_W = SZ_W + STEP_LG,
    localparam int ADDR_W = BASE_W + DISP_W + 3
) (
    input logic              clk,
    input logic              rst,
    input logic              dma_en,
    input logic              drain_mode,
    input logic [BASE_W-1:0] ring_base,
    input logic [SZ_W-1:0]   size_code,
    input logic [DISP_W-1:0] ring_idx,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DW-1:0]     mem_wdata,
    input logic              mem_ack,
    input logic              xfer_valid,
    input logic              xfer_ready,
    input logic [DW-1:0]     xfer_addr,
    input logic [LEN_W-1:0]  xfer_len,
    input logic              xfer_sop,
    input logic              xfer_eop,
    input logic              fifo_empty,
    input logic              desc_done,
    input logic              all_done
);

    logic xfer_seen;

    always_ff @(posedge clk) begin
        if (rst)
            xfer_seen <= 1'b0;
        else if (xfer_valid && xfer_ready)
            xfer_seen <= 1'b1;
        else if (mem_req && mem_we && mem_ack)
            xfer_seen <= 1'b0;
    end

    // R2
    xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr) &&
        $stable(xfer_len) && $stable(xfer_sop) && $stable(xfer_eop));

    // R3
    own_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> !mem_wdata[DW-1]);

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        desc_done |=> !desc_done);

    // R3
    return_after_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && (mem_wdata[LEN_W-1:0] != '0) |-> xfer_seen);

    // R4
    zero_len_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> xfer_len != '0);

    // R5
    addr_base_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[ADDR_W-1:ADDR_W-BASE_W] == ring_base) &&
        (mem_addr[1:0] == 2'b00));

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        ring_idx <= {size_code, {STEP_LG{1'b1}}});

    // R8
    fetch_enable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) && !mem_we |-> dma_en);

    // R10
    drain_wait_chk: assert property (@(posedge clk) disable iff (rst)
        all_done && drain_mode |-> $past(fifo_empty));

endmodule

bind txring_walker txw_checker #(
    .BASE_W  (BASE_W),
    .SZ_W    (SZ_W),
    .STEP_LG (STEP_LG)
) u_txw_checker (.*);

// File: tb/txring_walker_test.sv
module txring_walker_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [20:0] BASE = 21'h05A3C;
    localparam logic [31:0] MARK = 32'h2000_0A07;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dma_en = 1'b0;
    logic        drain_mode = 1'b0;
    logic [3:0]  size_code = 4'd0;
    logic        kick = 1'b0;
    logic [7:0]  ring_idx;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;
    logic        xfer_valid;
    logic        xfer_ready = 1'b0;
    logic [31:0] xfer_addr;
    logic [13:0] xfer_len;
    logic        xfer_sop, xfer_eop;
    logic        fifo_empty = 1'b1;
    logic        desc_done, all_done, eop_err;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    txring_walker uut (
        .clk(clk), .rst(rst), .dma_en(dma_en), .drain_mode(drain_mode),
        .ring_base(BASE), .size_code(size_code), .kick(kick),
        .ring_idx(ring_idx), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .xfer_valid(xfer_valid), .xfer_ready(xfer_ready),
        .xfer_addr(xfer_addr), .xfer_len(xfer_len), .xfer_sop(xfer_sop),
        .xfer_eop(xfer_eop), .fifo_empty(fifo_empty), .desc_done(desc_done),
        .all_done(all_done), .eop_err(eop_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // host memory model: two-cycle access, plus a bench-side write port
    logic [31:0] mem [0:511];
    logic        hw_en = 1'b0;
    logic [8:0]  hw_idx = '0;
    logic [31:0] hw_data = '0;
    int          bad_addr = 0;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            for (int i = 0; i < 512; i++) mem[i] <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) mem_rdata <= mem[mem_addr[10:2]];
            if (mem_req && mem_ack && mem_we) mem[mem_addr[10:2]] <= mem_wdata;
            if (mem_req && (mem_addr[31:11] != BASE || mem_addr[1:0] != 2'b00))
                bad_addr <= bad_addr + 1;
            if (hw_en) mem[hw_idx] <= hw_data;
        end
    end

    // output monitors
    int dd_cnt = 0, ad_cnt = 0, ee_cnt = 0, req_cyc = 0, x_n = 0;
    logic [31:0] x_addr [0:511];
    logic [15:0] x_info [0:511];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (desc_done) dd_cnt <= dd_cnt + 1;
            if (all_done)  ad_cnt <= ad_cnt + 1;
            if (eop_err)   ee_cnt <= ee_cnt + 1;
            if (mem_req)   req_cyc <= req_cyc + 1;
            if (xfer_valid && xfer_ready) begin
                x_addr[x_n[8:0]] <= xfer_addr;
                x_info[x_n[8:0]] <= {xfer_sop, xfer_eop, xfer_len};
                x_n <= x_n + 1;
            end
        end
    end

    always @(negedge clk) xfer_ready <= (cyc % 3) != 0;

    always @(posedge clk) begin
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_word(input int idx, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_idx = idx[8:0]; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic do_reset(input logic [3:0] code);
        @(negedge clk);
        rst = 1'b1; size_code = code;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    function automatic logic [31:0] mk_flags(input logic own, input logic sop,
            input logic eop, input int k, input logic [13:0] len);
        return {own, sop, eop, k[0], 8'(k * 3), 6'(k + 5), len};
    endfunction

    logic [31:0] e_flags [0:255];
    int          e_idx   [0:255];
    logic [31:0] ex_addr [0:255];
    logic [15:0] ex_info [0:255];

    // pattern 0: one descriptor per packet; pattern 1: SOP/EOP sequence
    task automatic run_batch(input int start, input int n, input int ents,
                             input int pattern, input logic drain);
        int x0, d0, a0, e0, ne, idx, m, t;
        logic sop, eop;
        logic [13:0] len;
        logic [31:0] ba;
        x0 = x_n; d0 = dd_cnt; a0 = ad_cnt; e0 = ee_cnt; ne = 0;
        for (int k = 0; k < n; k++) begin
            idx = (start + k) % ents;
            if (pattern == 0) begin
                sop = 1'b1; eop = 1'b1;
            end else begin
                sop = (k == 0 || k == 1 || k == 2 || k == 5);
                eop = (k == 1 || k == 4 || k == 5);
            end
            if (k % 5 == 3)      len = 14'd0;
            else if (k == 1)     len = 14'h3FFF;
            else                 len = 14'((k * 37 + start * 11 + 1) % 16000 + 1);
            ba = 32'h8000_0000 ^ (k * 32'h0101_0103) ^ idx;
            e_flags[k] = mk_flags(1'b1, sop, eop, k, len);
            e_idx[k] = idx;
            put_word(2 * idx, e_flags[k]);
            put_word(2 * idx + 1, ba);
            if (len != 0) begin
                ex_addr[ne] = ba;
                ex_info[ne] = {sop, eop, len};
                ne++;
            end
        end
        m = (start + n) % ents;
        put_word(2 * m, MARK);
        if (drain) begin
            @(negedge clk); fifo_empty = 1'b0; drain_mode = 1'b1;
        end
        pulse_kick();
        t = 0;
        if (drain) begin
            while (dd_cnt - d0 < n && t < 20000) begin @(negedge clk); t++; end
            repeat (20) @(negedge clk);
            // R10: no end pulse while FIFO still holds data
            chk(ad_cnt == a0, "R10 early all_done", 64'(ad_cnt - a0), 64'd0);
            fifo_empty = 1'b1;
            repeat (3) @(negedge clk);
            chk(ad_cnt == a0 + 1, "R10 all_done after drain", 64'(ad_cnt - a0), 64'd1);
            drain_mode = 1'b0;
        end else begin
            while (ad_cnt == a0 && t < 20000) begin @(negedge clk); t++; end
            repeat (4) @(negedge clk);
            chk(ad_cnt == a0 + 1, "R9 one all_done per walk", 64'(ad_cnt - a0), 64'd1);
        end
        chk(x_n - x0 == ne, "R2/R4 transfer count", 64'(x_n - x0), 64'(ne));
        for (int j = 0; j < ne; j++)
            chk({x_addr[(x0 + j) % 512], x_info[(x0 + j) % 512]} ==
                {ex_addr[j], ex_info[j]}, "R2 transfer fields",
                {x_addr[(x0 + j) % 512], x_info[(x0 + j) % 512]},
                {ex_addr[j], ex_info[j]});
        for (int k = 0; k < n; k++)
            chk(mem[2 * e_idx[k]] == (e_flags[k] & 32'h7FFF_FFFF),
                (e_flags[k][13:0] == 0) ? "R4 zero-length write-back" : "R3 write-back",
                64'(mem[2 * e_idx[k]]), 64'(e_flags[k] & 32'h7FFF_FFFF));
        chk(dd_cnt - d0 == n, "R3 desc_done count", 64'(dd_cnt - d0), 64'(n));
        chk(mem[2 * m] == MARK, "R7 software slot untouched", 64'(mem[2 * m]), 64'(MARK));
        chk(ring_idx == m[7:0], "R6 index after walk", 64'(ring_idx), 64'(m));
        chk(ee_cnt - e0 == ((pattern == 1) ? 1 : 0), "R11 eop_err count",
            64'(ee_cnt - e0), 64'((pattern == 1) ? 1 : 0));
    endtask

    initial begin
        int r0, a0, x0;
        do_reset(4'd0);
        // R1
        chk({mem_req, xfer_valid, desc_done, all_done, eop_err} == 5'b0,
            "R1 outputs after reset", 64'({mem_req, xfer_valid, desc_done, all_done, eop_err}), 64'd0);
        chk(ring_idx == 8'd0, "R1 index after reset", 64'(ring_idx), 64'd0);

        // R8: kick with fetching disabled stays pending
        put_word(0, mk_flags(1'b1, 1'b1, 1'b1, 0, 14'd64));
        put_word(1, 32'h1234_5670);
        r0 = req_cyc; a0 = ad_cnt;
        pulse_kick();
        repeat (30) @(negedge clk);
        chk(req_cyc == r0, "R8 no access while disabled", 64'(req_cyc - r0), 64'd0);
        dma_en = 1'b1;
        repeat (30) @(negedge clk);
        chk(ad_cnt == a0 + 1, "R8 pending kick served", 64'(ad_cnt - a0), 64'd1);
        chk(mem[0] == (mk_flags(1'b1, 1'b1, 1'b1, 0, 14'd64) & 32'h7FFF_FFFF),
            "R8 descriptor returned", 64'(mem[0]),
            64'(mk_flags(1'b1, 1'b1, 1'b1, 0, 14'd64) & 32'h7FFF_FFFF));
        chk(ring_idx == 8'd1, "R8 index advanced", 64'(ring_idx), 64'd1);

        run_batch(1, 13, 16, 0, 1'b0);
        run_batch(14, 5, 16, 0, 1'b0);   // crosses the wrap, R6

        // R7/R9: kick with nothing owned
        a0 = ad_cnt; x0 = x_n;
        pulse_kick();
        repeat (30) @(negedge clk);
        chk(ad_cnt == a0, "R9 no all_done on empty walk", 64'(ad_cnt - a0), 64'd0);
        chk(x_n == x0, "R7 no transfer on software slot", 64'(x_n - x0), 64'd0);
        chk(ring_idx == 8'd3, "R7 index holds", 64'(ring_idx), 64'd3);

        run_batch(3, 4, 16, 0, 1'b1);    // R10
        run_batch(7, 6, 16, 1, 1'b0);    // R11

        do_reset(4'd1);
        run_batch(0, 30, 32, 0, 1'b0);
        run_batch(30, 6, 32, 0, 1'b0);

        do_reset(4'd15);
        run_batch(0, 254, 256, 0, 1'b0);
        run_batch(254, 4, 256, 0, 1'b0);

        // R5
        chk(bad_addr == 0, "R5 descriptor addressing", 64'(bad_addr), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule